// File: doc/BRIEF.md
# Prescaled Multi-Channel PWM Generator

This block produces up to four independent pulse-width-modulated outputs. Each output has one 32-bit control word, written and read back over a simple memory-mapped bus. The word holds three fields: a run flag, an 8-bit on-time, and a 13-bit clock divider. Every output period is exactly 256 ticks long. One tick lasts the divider field plus one input clock cycles. The output is high for the first "on-time" ticks of each period.

Software sets the divider and on-time, then sets the run flag. The on-time and divider can be retuned while the channel runs. Such an update is held until the current period ends, so the channel never emits a cut-short pulse. Writing an all-zero word stops the channel and clears its configuration. The number of channels is a build-time parameter, either 4 or 1.

Top module: `pwm_bank`

## Requirements
- R1: Control word layout: bit 31 is the run flag, bits 23:16 hold the on-time, and bits 12:0 hold the divider. A read returns the last value written, with bits 30:24 and 15:13 always reading as zero.
- R2: Channel i sits at byte address 16·i, so address bits 5:4 select the channel. An access with a nonzero address[3:0] reads zero and its write is ignored. An access to a channel index at or above NUM_CH also reads zero and its write is ignored.
- R3: While running, the output is high exactly while the tick count (0..255) is below the on-time. An on-time of 0 gives a constant low output.
- R4: Each tick lasts (divider + 1) clock cycles, so one period lasts 256·(divider + 1) cycles. A divider of 0 gives one cycle per tick.
- R5: While the run flag is clear, the output is low from the first cycle after the write that cleared it. The channel's counters stay at zero during that time.
- R6: A write that sets the run flag is taken at a clock edge. The output stays low in the cycle after that edge. Tick 0 of a fresh period begins one edge later, using the configuration just written.
- R7: An on-time or divider change written while the channel runs takes effect only at the start of the next period.
- R8: Writing zero to a channel stops it and clears its on-time and divider. A later read returns zero.
- R9: After synchronous active-low reset, every control word reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 6 | Byte address of the access |
| bus_wr | input | 1 | Write strobe; the data is taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench builds two copies of the block. Both share one bus, and both are checked every cycle against a period model kept in the bench. The copy with NUM_CH = 4 exercises all four channels together: independent on-times, dividers up to the 13-bit maximum, and mid-period retuning. The copy with NUM_CH = 1 places addresses 0x10 through 0x30 beyond the channel count. That is the only way to observe the rule that such reads return zero and such writes are dropped, while channel 0 of that copy must keep following the model.

// File: rtl/pwm_bank_pkg.sv
// Package: field positions and the per-channel configuration type.
// Assumes a 32-bit control word and a 16-byte channel stride.
package pwm_bank_pkg;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 32;
    localparam int SEL_LSB   = 4;
    localparam int RUN_BIT   = 31;
    localparam int ONT_LSB   = 16;
    localparam int ONT_W     = 8;
    localparam int DIV_LSB   = 0;
    localparam int DIV_W     = 13;
    localparam int MAX_CH    = 1 << (ADDR_W - SEL_LSB);

    typedef struct packed {
        logic              run;
        logic [ONT_W-1:0]  on_time;
        logic [DIV_W-1:0]  divider;
    } pwm_cfg_t;

    // Rebuild the bus view of a configuration; reserved bits read zero.
    function automatic logic [DATA_W-1:0] cfg_to_word(input pwm_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[RUN_BIT] = c.run;
        w[ONT_LSB +: ONT_W] = c.on_time;
        w[DIV_LSB +: DIV_W] = c.divider;
        return w;
    endfunction

    // Pick the fields out of a written word.
    function automatic pwm_cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
        pwm_cfg_t c;
        c.run     = w[RUN_BIT];
        c.on_time = w[ONT_LSB +: ONT_W];
        c.divider = w[DIV_LSB +: DIV_W];
        return c;
    endfunction
endpackage

// File: rtl/pwm_tick_div.sv
// Module: tick divider. Emits a one-cycle strobe every (limit + 1)
// cycles while clr is low. Assumes limit stays stable while it counts.
module pwm_tick_div #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] limit,
    output logic             tick_stb
);
    logic [DIV_W-1:0] cnt;

    assign tick_stb = !clr && (cnt == limit);

    // Count cycles within one tick; wrap at the limit, hold zero when cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_chan.sv
// Module: one PWM channel. Holds the active on-time and divider and an
// 8-bit tick counter. It takes new settings from cfg at each period end,
// and continuously while idle. Assumes cfg comes straight from the control word.
module pwm_chan
    import pwm_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pwm_cfg_t cfg,
    output logic     pwm_o
);
    logic             running;
    logic             idle;
    logic             tick_stb;
    logic [ONT_W-1:0] tick;
    logic [ONT_W-1:0] on_act;
    logic [DIV_W-1:0] div_act;

    assign idle = !cfg.run || !running;

    pwm_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (idle),
        .limit    (div_act),
        .tick_stb (tick_stb)
    );

    // Track whether a period is in progress; it starts one edge after the run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
        end else begin
            running <= cfg.run;
        end
    end

    // Tick counter plus the active copy, reloaded when idle or at period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick    <= '0;
            on_act  <= '0;
            div_act <= '0;
        end else if (idle) begin
            tick    <= '0;
            on_act  <= cfg.on_time;
            div_act <= cfg.divider;
        end else if (tick_stb) begin
            tick <= tick + 1'b1;
            if (tick == {ONT_W{1'b1}}) begin
                on_act  <= cfg.on_time;
                div_act <= cfg.divider;
            end
        end
    end

    assign pwm_o = cfg.run && running && (tick < on_act);
endmodule

// File: rtl/pwm_bank.sv
// Module: top of the PWM bank. Decodes the bus, stores one control word
// per channel and instantiates the channels. Assumes single-cycle writes
// and combinational reads; NUM_CH is 1..4.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int SEL_W = ADDR_W - SEL_LSB;

    logic [SEL_W-1:0]  sel;
    logic              hit;
    pwm_cfg_t          ctl [NUM_CH];
    logic [NUM_CH-1:0] run_vec;

    assign sel = bus_addr[ADDR_W-1:SEL_LSB];
    assign hit = (bus_addr[SEL_LSB-1:0] == '0) && (int'(sel) < NUM_CH);

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            // Capture the control word on a decoded write to this channel.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctl[i] <= '0;
                end else if (bus_wr && hit && (int'(sel) == i)) begin
                    ctl[i] <= word_to_cfg(bus_wdata);
                end
            end

            assign run_vec[i] = ctl[i].run;

            pwm_chan u_chan (
                .clk   (clk),
                .rst_n (rst_n),
                .cfg   (ctl[i]),
                .pwm_o (pwm_out[i])
            );
        end
    endgenerate

    // Read mux: the selected control word, or zero when nothing is decoded.
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit && (int'(sel) == i)) begin
                bus_rdata = cfg_to_word(ctl[i]);
            end
        end
    end
endmodule

// File: rtl/pwm_bank_chk.sv
// Module: property checker for pwm_bank, attached by bind below.
// Assumes it sees the bus, the outputs and the stored run flags.
module pwm_bank_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] run_vec
);
    // R1: reserved bits always read as zero.
    a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[30:24] == 7'd0) && (bus_rdata[15:13] == 3'd0));

    // R2: a misaligned address reads zero.
    a_r2_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[3:0] != 4'd0) |-> (bus_rdata == 32'd0));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_p
            // R5: a stopped channel drives low.
            a_r5_off_low: assert property (@(posedge clk) disable iff (!rst_n)
                !run_vec[i] |-> !pwm_out[i]);

            // R6: the first cycle after the run flag rises is still low.
            a_r6_start_low: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(run_vec[i]) |-> !pwm_out[i]);

            // R1: an aligned write lands in the run flag on the next cycle.
            a_r1_run_write: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_wr && bus_addr == 6'(i * 16)) |=> (run_vec[i] == $past(bus_wdata[31])));
        end
    endgenerate
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .run_vec   (run_vec)
);

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic [3:0]  out0;
    logic [0:0]  out1;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    string phase = "R9";

    // Model state per channel
    logic [31:0] m_reg [4];
    bit          m_run [4];
    int          m_pos [4];
    int          m_on  [4];
    int          m_div [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bank #(.NUM_CH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .pwm_out(out0));

    pwm_bank #(.NUM_CH(1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .pwm_out(out1));

    function automatic bit exp_out(int ch);
        return m_reg[ch][31] && m_run[ch] && (m_pos[ch] < m_on[ch] * (m_div[ch] + 1));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    // Period model: R3 R4 R5 R6 R7 R8, from the requirement text.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_reg[c] <= '0; m_run[c] <= 0; m_pos[c] <= 0; m_on[c] <= 0; m_div[c] <= 0;
            end
        end else begin
            for (int c = 0; c < 4; c++) begin
                if (!m_reg[c][31] || !m_run[c]) begin
                    m_pos[c] <= 0;
                    m_on[c]  <= int'(m_reg[c][23:16]);
                    m_div[c] <= int'(m_reg[c][12:0]);
                end else if (m_pos[c] == 256 * (m_div[c] + 1) - 1) begin
                    m_pos[c] <= 0;
                    m_on[c]  <= int'(m_reg[c][23:16]);
                    m_div[c] <= int'(m_reg[c][12:0]);
                end else begin
                    m_pos[c] <= m_pos[c] + 1;
                end
                m_run[c] <= m_reg[c][31];
            end
            if (bus_wr && bus_addr[3:0] == 4'd0)
                m_reg[bus_addr[5:4]] <= bus_wdata & 32'h80FF_1FFF;
        end
    end

    // Output comparison each cycle, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 4; c++)
                check({phase, " out"}, 32'(out0[c]), 32'(exp_out(c)));
            check({phase, " R2 u1 out"}, 32'(out1[0]), 32'(exp_out(0)));
        end
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd0(string req, logic [5:0] a, logic [31:0] exp);
        bus_addr = a; #1;
        check(req, rdata0, exp);
    endtask

    task automatic rd1(string req, logic [5:0] a, logic [31:0] exp);
        bus_addr = a; #1;
        check(req, rdata1, exp);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        for (int c = 0; c < 4; c++) rd0("R9 reset read", 6'(c * 16), 32'd0);
        check("R9 reset out", 32'(out0), 32'd0);

        // R1: layout and reserved bits
        phase = "R1";
        wr(6'h00, 32'hFFFF_FFFF);
        rd0("R1 readback", 6'h00, 32'h80FF_1FFF);
        wr(6'h00, 32'h0000_0000);
        rd0("R8 cleared", 6'h00, 32'd0);

        // R2: misaligned and out-of-range accesses
        phase = "R2";
        wr(6'h24, 32'h8012_0003);
        rd0("R2 misaligned read", 6'h24, 32'd0);
        rd0("R2 misaligned write ignored", 6'h20, 32'd0);
        wr(6'h00, 32'h0034_0005);
        wr(6'h10, 32'h0056_0007);
        rd1("R2 u1 beyond NUM_CH read", 6'h10, 32'd0);
        rd1("R2 u1 ch0 untouched", 6'h00, 32'h0034_0005);
        rd0("R2 u0 ch1 stored", 6'h10, 32'h0056_0007);
        wr(6'h00, 32'd0);
        wr(6'h10, 32'd0);

        // R3: on-time zero stays low; on-time 255 at divider 0
        phase = "R3";
        wr(6'h00, 32'h8000_0000);
        idle(300);
        wr(6'h10, 32'h80FF_0000);
        idle(600);

        // R6: start timing checked directly
        phase = "R6";
        wr(6'h20, 32'h8004_0001);
        check("R6 low after enable", 32'(out0[2]), 32'd0);
        @(negedge clk);
        check("R6 high at tick 0", 32'(out0[2]), 32'd1);

        // R7: retune mid-period; model holds the change to the boundary
        phase = "R7";
        idle(100);
        wr(6'h20, 32'h8080_0000);
        idle(700);

        // R4: maximum divider, one high tick of 8192 cycles
        phase = "R4";
        wr(6'h30, 32'h8001_1FFF);
        idle(8300);

        // R5 R8: stop all
        phase = "R5";
        for (int c = 0; c < 4; c++) wr(6'(c * 16), 32'd0);
        idle(20);
        check("R5 all low", 32'(out0), 32'd0);

        // Random mix: R3 R4 R7 R5
        phase = "R3 R4 R7 random";
        for (int it = 0; it < 60; it++) begin
            int ch;
            logic [31:0] w;
            ch = int'($urandom_range(0, 3));
            w = {($urandom_range(0, 3) != 0), 7'($urandom), 8'($urandom),
                 3'($urandom), 13'($urandom_range(0, 3))};
            wr(6'(ch * 16), w);
            rd0("R1 random readback", 6'(ch * 16), w & 32'h80FF_1FFF);
            idle(int'($urandom_range(20, 900)));
        end

        finish_run();
    end
endmodule